// File: doc/BRIEF.md
# Static Memory Cycle Sequencer

This block times one access to an SRAM-style device on a single chip select. After a one-clock start request it drives active-low chip select, output enable, write enable and four byte-lane enables across a fixed lead clock, a run of wait clocks and a closing clock. The number of wait clocks comes from a programmed wait count, or from an external acknowledge input on ports set up for it. When bursts are enabled, the first access is followed by further beats. Each later beat lasts a programmed number of clocks, and the size code sets how many beats there are.

The block raises a last-beat flag for the whole final beat and a one-clock completion pulse in the final clock of that beat. An optional trailing quiet clock can follow the access. During that clock all strobes are released and a new request is not accepted. Configuration fields, the direction, the low address bits and the transfer size are captured when the request is accepted and stay fixed for the rest of the access.

The state machine has six states:
- `ST_IDLE`: waits for `start`.
- `ST_T1`: the lead clock.
- `ST_TW`: the wait clocks.
- `ST_T2`: the closing clock of the first beat.
- `ST_BEAT`: the clocks of each later burst beat.
- `ST_GAP`: the trailing quiet clock.

Its transitions are:
- IDLE→T1 on `start`.
- T1→TW when a wait is due, otherwise T1→T2.
- TW→T2 on timer expiry, or on acknowledge in acknowledge mode.
- T2→BEAT while beats remain.
- BEAT→BEAT at each beat end while beats remain.
- T2 or BEAT → GAP at the final beat end if the quiet clock is enabled, otherwise → IDLE.
- GAP→IDLE always.

Top module: `smc_seq`

## Requirements
- R1: After reset, `cs_n`, `oe_n`, `we_n` are 1, `be_n` is 4'hF, and `done` and `last` are 0.
- R2: With `cfg_sync`=1 and acknowledge mode off, a single access holds `cs_n` low for 2 + `cfg_wait` clocks (`cfg_wait` 0 to 15).
- R3: With `cfg_sync`=0, a `cfg_wait` of 0 gives the same length as 1: 3 clocks.
- R4: Acknowledge mode is on when `cfg_port`=11, or when `cfg_ack_sel`=1 and `cfg_port` is 01 or 10. It is off for `cfg_port`=00 whatever `cfg_ack_sel` is. In acknowledge mode the wait count is ignored, and the wait clocks last until `xfer_ack` is sampled high during one of them, so a pulse in the K-th wait clock gives a length of K+2.
- R5: `cs_n` is low on every clock of the access. On reads (`wr_en`=0) `oe_n` is low on every one of those clocks and `we_n` stays high. On writes `we_n` is low on all but the first clock and `oe_n` stays high. `oe_n` and `we_n` are never low together.
- R6: `be_n` is active-low, with bit 3 for data bits 31:24 and bit 0 for bits 7:0. It stays at 4'hF outside an access. `xfer_size` is coded 00 byte, 01 halfword, 10/11 word. `cfg_port` is coded 00 32-bit, 01 16-bit, 10 8-bit, 11 32-bit with acknowledge. The enabled lanes are as follows:
  - 8-bit port: lane 3 only.
  - 16-bit port, byte transfer: lane 3 when `addr_lo[0]`=0, lane 2 otherwise.
  - 16-bit port, wider transfers: lanes 3:2.
  - 32-bit port, byte transfer: lane 3−`addr_lo`.
  - 32-bit port, halfword transfer: lanes 3:2 when `addr_lo[1]`=0, lanes 1:0 otherwise.
  - 32-bit port, word transfer: all four lanes.
- R7: With `cfg_burst`=1 an access has 2<<`cfg_bsize` beats (2, 4, 8, 16), and each beat after the first lasts `cfg_beat`+1 clocks. With `cfg_burst`=0 an access is one beat whatever `cfg_bsize` is.
- R8: `last` is high on every clock of the final beat and low on all earlier beats.
- R9: `done` is high for exactly one clock per access, the final clock during which `cs_n` is low.
- R10: With `cfg_idle`=1, the clock after the access has `cs_n` high and a `start` then is ignored. With `cfg_idle`=0, a `start` in that clock begins a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request, sampled in idle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr_lo | input | 2 | Low byte-address bits |
| xfer_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| cfg_wait | input | WAIT_W | Wait clocks between lead and closing clock |
| cfg_sync | input | 1 | 1 = synchronous device, 0 = asynchronous (one-wait floor) |
| cfg_idle | input | 1 | Append one quiet clock after the access |
| cfg_burst | input | 1 | Burst enable |
| cfg_beat | input | BEAT_W | Later-beat length code, length = code + 1 |
| cfg_bsize | input | BSZ_W | Burst beat count code, beats = 2 << code |
| cfg_port | input | 2 | Port width code |
| cfg_ack_sel | input | 1 | Request acknowledge mode on narrow ports |
| xfer_ack | input | 1 | External transfer acknowledge, active high |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_n | output | 4 | Byte-lane enables, active low |
| done | output | 1 | Completion pulse |
| last | output | 1 | Final-beat flag |

## Verification
The bench builds the block with its default widths: a 4-bit wait field and 2-bit beat and size codes. This brings the full range of 0 to 15 wait clocks, beats of 1 to 4 clocks and bursts of up to 16 beats within reach. The longest access, at 77 clocks, stays short enough that a few hundred random accesses fit easily. Random accesses cover every combination of port code, transfer size, address offset, direction, sync mode and acknowledge selection, with acknowledge pulses arriving after 1 to 6 wait clocks. Directed cases cover the async zero-wait floor, acknowledge selection on a plain 32-bit port, the longest burst, a burst size set with bursts disabled, and the quiet clock with a request pressed against it.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_TW,
        ST_T2,
        ST_BEAT,
        ST_GAP
    } smc_state_e;

    localparam logic [1:0] PORT_W32     = 2'b00;
    localparam logic [1:0] PORT_W16     = 2'b01;
    localparam logic [1:0] PORT_W8      = 2'b10;
    localparam logic [1:0] PORT_W32_ACK = 2'b11;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

endpackage

// File: rtl/smc_dcnt.sv
module smc_dcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/smc_lane_dec.sv
module smc_lane_dec
    import smc_pkg::*;
(
    input  logic [1:0] port,
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic [3:0] be_n
);
    logic [3:0] lane_en;

    always_comb begin
        unique case (port)
            PORT_W8: begin
                lane_en = 4'b1000;
            end
            PORT_W16: begin
                if (size == SZ_BYTE) begin
                    lane_en = addr_lo[0] ? 4'b0100 : 4'b1000;
                end else begin
                    lane_en = 4'b1100;
                end
            end
            default: begin
                if (size == SZ_BYTE) begin
                    lane_en = 4'b1000 >> addr_lo;
                end else if (size == SZ_HALF) begin
                    lane_en = addr_lo[1] ? 4'b0011 : 4'b1100;
                end else begin
                    lane_en = 4'b1111;
                end
            end
        endcase
    end

    assign be_n = ~lane_en;
endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int BSZ_W  = 2,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        xfer_size,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_sync,
    input  logic              cfg_idle,
    input  logic              cfg_burst,
    input  logic [BEAT_W-1:0] cfg_beat,
    input  logic [BSZ_W-1:0]  cfg_bsize,
    input  logic [1:0]        cfg_port,
    input  logic              cfg_ack_sel,
    input  logic              xfer_ack,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [3:0]        be_n,
    output logic              done,
    output logic              last
);
    // beat count reaches 2 << (2**BSZ_W - 1)
    localparam int BCNT_W = (1 << BSZ_W) + 1;
    localparam int TMR_W  = (WAIT_W > BEAT_W) ? WAIT_W : BEAT_W;

    smc_state_e state, state_nx;

    logic              wr_q;
    logic [3:0]        be_q;
    logic              ack_q;
    logic              idle_q;
    logic [TMR_W-1:0]  wait_q;
    logic [TMR_W-1:0]  blen_q;

    logic [3:0]        be_dec;
    logic [TMR_W-1:0]  wait_eff;
    logic              ack_mode;
    logic [BCNT_W-1:0] beats_total;
    logic              accept;

    logic              tmr_ld;
    logic              tmr_dec;
    logic [TMR_W-1:0]  tmr_val;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_zero;

    logic              bc_dec;
    logic [BCNT_W-1:0] bc_cnt;
    logic              is_last;
    logic              beat_end;

    smc_lane_dec lane_i (
        .port    (cfg_port),
        .size    (xfer_size),
        .addr_lo (addr_lo),
        .be_n    (be_dec)
    );

    smc_dcnt #(.W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .cnt      (tmr_cnt)
    );

    smc_dcnt #(.W(BCNT_W)) beat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (beats_total),
        .dec      (bc_dec),
        .cnt      (bc_cnt)
    );

    assign accept      = (state == ST_IDLE) && start;
    assign wait_eff    = (!cfg_sync && (cfg_wait == '0)) ? TMR_W'(1) : TMR_W'(cfg_wait);
    assign ack_mode    = (cfg_port == PORT_W32_ACK) || (cfg_ack_sel && (cfg_port != PORT_W32));
    assign beats_total = cfg_burst ? (BCNT_W'(2) << cfg_bsize) : BCNT_W'(1);
    assign tmr_zero    = (tmr_cnt == '0);
    assign is_last     = (bc_cnt == BCNT_W'(1));
    assign beat_end    = (state == ST_T2) || ((state == ST_BEAT) && tmr_zero);
    assign bc_dec      = beat_end && !is_last;

    // access parameters captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            be_q   <= 4'hF;
            ack_q  <= 1'b0;
            idle_q <= 1'b0;
            wait_q <= '0;
            blen_q <= '0;
        end else if (accept) begin
            wr_q   <= wr_en;
            be_q   <= be_dec;
            ack_q  <= ack_mode;
            idle_q <= cfg_idle;
            wait_q <= wait_eff;
            blen_q <= TMR_W'(cfg_beat);
        end
    end

    // timer control: wait run after T1, beat length on each new beat
    always_comb begin
        tmr_ld  = 1'b0;
        tmr_val = '0;
        if ((state == ST_T1) && (state_nx == ST_TW)) begin
            tmr_ld  = 1'b1;
            tmr_val = wait_q - 1'b1;
        end else if (beat_end && (state_nx == ST_BEAT)) begin
            tmr_ld  = 1'b1;
            tmr_val = blen_q;
        end
        tmr_dec = ((state == ST_TW) && !ack_q) || (state == ST_BEAT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_T1;
            end
            ST_T1: begin
                state_nx = (ack_q || (wait_q != '0)) ? ST_TW : ST_T2;
            end
            ST_TW: begin
                if (ack_q ? xfer_ack : tmr_zero) state_nx = ST_T2;
            end
            ST_T2: begin
                if (!is_last)    state_nx = ST_BEAT;
                else if (idle_q) state_nx = ST_GAP;
                else             state_nx = ST_IDLE;
            end
            ST_BEAT: begin
                if (tmr_zero) begin
                    if (!is_last)    state_nx = ST_BEAT;
                    else if (idle_q) state_nx = ST_GAP;
                    else             state_nx = ST_IDLE;
                end
            end
            ST_GAP: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        cs_n = 1'b1;
        oe_n = 1'b1;
        we_n = 1'b1;
        be_n = 4'hF;
        last = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_T1: begin
                cs_n = 1'b0;
                oe_n = wr_q;
                be_n = be_q;
                last = is_last;
            end
            ST_TW, ST_T2, ST_BEAT: begin
                cs_n = 1'b0;
                oe_n = wr_q;
                we_n = !wr_q;
                be_n = be_q;
                last = is_last;
                done = is_last && beat_end;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/smc_seq_chk.sv
module smc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       oe_n,
    input logic       we_n,
    input logic [3:0] be_n,
    input logic       done,
    input logic       last
);
    // R5
    strobes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (oe_n && we_n && (be_n == 4'hF) && !last));

    // R5
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R5
    we_after_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> we_n);

    // R9
    done_in_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs_n && last));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    last_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(last) |-> cs_n);

    // R9
    done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cs_n);
endmodule

bind smc_seq smc_seq_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .be_n  (be_n),
    .done  (done),
    .last  (last)
);

// File: tb/smc_seq_tb_top.sv
module smc_seq_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr_lo = 2'b00;
    logic [1:0] xfer_size = 2'b10;
    logic [3:0] cfg_wait = 4'd0;
    logic       cfg_sync = 1'b1;
    logic       cfg_idle = 1'b0;
    logic       cfg_burst = 1'b0;
    logic [1:0] cfg_beat = 2'd0;
    logic [1:0] cfg_bsize = 2'd0;
    logic [1:0] cfg_port = 2'b00;
    logic       cfg_ack_sel = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       cs_n, oe_n, we_n, done, last;
    logic [3:0] be_n;

    int checks = 0;
    int errors = 0;

    smc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .addr_lo(addr_lo), .xfer_size(xfer_size), .cfg_wait(cfg_wait),
        .cfg_sync(cfg_sync), .cfg_idle(cfg_idle), .cfg_burst(cfg_burst),
        .cfg_beat(cfg_beat), .cfg_bsize(cfg_bsize), .cfg_port(cfg_port),
        .cfg_ack_sel(cfg_ack_sel), .xfer_ack(xfer_ack),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .be_n(be_n),
        .done(done), .last(last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit ack_on();
        return (cfg_port == 2'b11) || (cfg_ack_sel && (cfg_port != 2'b00));
    endfunction

    function automatic int beat_count();
        return cfg_burst ? (2 << cfg_bsize) : 1;
    endfunction

    function automatic int access_len(input int ack_k);
        int w;
        if (ack_on()) w = ack_k;
        else if (!cfg_sync && cfg_wait == 0) w = 1;
        else w = int'(cfg_wait);
        return 2 + w + (beat_count() - 1) * (int'(cfg_beat) + 1);
    endfunction

    function automatic logic [3:0] lanes_n();
        int pb, wb, n, off;
        logic [3:0] m;
        pb = (cfg_port == 2'b01) ? 2 : (cfg_port == 2'b10) ? 1 : 4;
        wb = (xfer_size == 2'b00) ? 1 : (xfer_size == 2'b01) ? 2 : 4;
        n = (wb < pb) ? wb : pb;
        off = (int'(addr_lo) % pb) & ~(n - 1);
        m = 4'b0000;
        for (int b = 0; b < n; b++) m[3 - off - b] = 1'b1;
        return ~m;
    endfunction

    function automatic string len_tag(input int ack_k);
        if (ack_k > 0 || ack_on()) return "R4";
        if (cfg_burst) return "R7";
        if (!cfg_sync && cfg_wait == 0) return "R3";
        return "R2";
    endfunction

    task automatic do_txn(input int ack_k);
        int ncs = 0, nwe = 0, noe = 0, ndone = 0, done_idx = -1, nlast = 0;
        int i = 0, exp_len, exp_last;
        bit be_bad = 0, last_gap = 0;
        logic [3:0] exp_be;
        exp_be   = lanes_n();
        exp_len  = access_len(ack_k);
        exp_last = (beat_count() == 1) ? exp_len : int'(cfg_beat) + 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!cs_n && i < 200) begin
            ncs++;
            if (!we_n) nwe++;
            if (!oe_n) noe++;
            if (be_n !== exp_be) be_bad = 1;
            if (done) begin ndone++; done_idx = i; end
            if (last) nlast++;
            else if (nlast > 0) last_gap = 1;
            xfer_ack = (ack_k > 0) && (i == ack_k);
            @(negedge clk);
            i++;
        end
        xfer_ack = 1'b0;
        check(ncs == exp_len, len_tag(ack_k), "cs_n low clocks", ncs, exp_len);
        check(nwe == (wr_en ? exp_len - 1 : 0), "R5", "we_n low clocks", nwe,
              wr_en ? exp_len - 1 : 0);
        check(noe == (wr_en ? 0 : exp_len), "R5", "oe_n low clocks", noe,
              wr_en ? 0 : exp_len);
        check(!be_bad, "R6", "be_n lanes", int'(be_bad), 0);
        check(ndone == 1 && done_idx == exp_len - 1, "R9", "done position", done_idx,
              exp_len - 1);
        check(nlast == exp_last && !last_gap, "R8", "last clocks", nlast, exp_last);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd48611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n && oe_n && we_n && be_n == 4'hF && !done && !last, "R1",
              "reset outputs", int'({cs_n, oe_n, we_n, done, last}), 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && oe_n && we_n && be_n == 4'hF && !done && !last, "R1",
              "idle outputs", int'({cs_n, oe_n, we_n, done, last}), 5'b11100);

        // R2 sync zero wait write, and maximum wait read
        wr_en = 1; cfg_sync = 1; cfg_wait = 0;
        do_txn(0); settle();
        wr_en = 0; cfg_wait = 15;
        do_txn(0); settle();
        // R3 async floor, zero and one behave alike
        cfg_sync = 0; cfg_wait = 0;
        do_txn(0); settle();
        cfg_wait = 1;
        do_txn(0); settle();
        // R4 selection ignored on plain 32-bit port
        cfg_sync = 1; cfg_wait = 5; cfg_ack_sel = 1; cfg_port = 2'b00;
        do_txn(0); settle();
        // R4 acknowledge port: wait count ignored
        cfg_ack_sel = 0; cfg_port = 2'b11; cfg_wait = 9;
        do_txn(4); settle();
        cfg_ack_sel = 1; cfg_port = 2'b10; xfer_size = 2'b00;
        do_txn(1); settle();
        // R7 longest burst and burst disabled
        cfg_ack_sel = 0; cfg_port = 2'b00; xfer_size = 2'b10; wr_en = 1;
        cfg_burst = 1; cfg_bsize = 2'd3; cfg_beat = 2'd3; cfg_wait = 2;
        do_txn(0); settle();
        cfg_burst = 0;
        do_txn(0); settle();
        // R6 lane cases
        cfg_port = 2'b01; xfer_size = 2'b00; addr_lo = 2'b11;
        do_txn(0); settle();
        cfg_port = 2'b00; xfer_size = 2'b01; addr_lo = 2'b10;
        do_txn(0); settle();

        // R10 quiet clock blocks a request pressed against it
        cfg_idle = 1; xfer_size = 2'b10; addr_lo = 0;
        do_txn(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int lows = 0;
            for (int k = 0; k < 3; k++) begin
                if (!cs_n) lows++;
                @(negedge clk);
            end
            check(lows == 0, "R10", "cs_n low after ignored start", lows, 0);
        end
        // R10 without quiet clock the request is taken at once
        cfg_idle = 0;
        do_txn(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!cs_n, "R10", "back-to-back start cs_n", int'(cs_n), 0);
        while (!cs_n) @(negedge clk);
        settle();

        // random accesses
        for (int t = 0; t < 300; t++) begin
            int k;
            wr_en       = 1'($urandom);
            addr_lo     = 2'($urandom);
            xfer_size   = 2'($urandom);
            cfg_wait    = 4'($urandom);
            cfg_sync    = 1'($urandom);
            cfg_idle    = 1'($urandom);
            cfg_burst   = ($urandom % 3) == 0;
            cfg_beat    = 2'($urandom);
            cfg_bsize   = 2'($urandom);
            cfg_port    = 2'($urandom);
            cfg_ack_sel = 1'($urandom);
            k = ack_on() ? 1 + int'($urandom % 6) : 0;
            do_txn(k);
            settle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule